// File: doc/BRIEF.md
# Power Domain Isolation and Reset Sequencer

This block drives the control lines of several switchable power domains. Each domain owns three control fields. The first is a power-switch field, where 1 means powered down. The second is an isolation field, active low, where 0 means the outputs are clamped. The third is a set of active-low reset lines. The fields live in three 32-bit control words: power, isolation and software reset. A single sequencer changes these words in a fixed, interlocked order whenever a requester asks for a domain to change state.

A requester raises `req_valid` with a domain index and a direction, and holds them until `req_ack` pulses. The sequencer steps through its states:

- Power-down path: `S_IDLE` → `S_ISO_EN` → `S_RST_ASSERT` → `S_PWR_DOWN` → `S_ACK`.
- Power-up path: `S_IDLE` → `S_PWR_UP` → `S_RST_RELEASE` → `S_ISO_DIS` → `S_ACK`.

After any step that changes a word, the sequencer passes through `S_SETTLE` for a programmable number of cycles and then returns to the next step. A step whose mask is empty moves straight to the next step, with no settle phase. A request that asks for the state the domain is already in goes from `S_IDLE` directly to `S_ACK`. `S_ACK` always returns to `S_IDLE`.

Software can also write and read whole words over a small register port. This lets it hold any reset line, or pulse one by writing twice. Such writes are refused while the sequencer is busy.

Top module: `pwrdom_seq`

## Requirements
- R1: After reset the power word is 0, the isolation and reset words are all ones, the settle register reads 16, every domain reports on, and `req_ack` and `wr_stall` are low.
- R2: A power-down request clears the domain's isolation bits, then clears its reset bits, then sets its power bits. Each change comes settle+1 cycles after the previous one.
- R3: A power-up request clears the domain's power bits, then sets its reset bits, then sets its isolation bits. Each change comes settle+1 cycles after the previous one.
- R4: A step whose mask is empty for the chosen domain changes nothing and adds no settle phase, so the gap across it is settle+2 cycles.
- R5: `req_ack` is high for exactly one cycle. It rises settle cycles after the final word change of a sequence.
- R6: `wr_stall` is high while a sequence runs or `req_valid` is high, and a write presented while stalled is dropped.
- R7: A request for the state a domain is already in acknowledges one cycle after it is presented and changes no word. Power-down is already reached when all of the domain's power bits are 1; power-up when all are 0.
- R8: A write with `wr_sel` 0, 1 or 2 replaces the power, isolation or reset word. Two writes, the first with one reset bit cleared and the second with it set, pulse that one reset line and leave the others unchanged. `rd_sel` reads the same encoding combinationally.
- R9: `dom_on_o[d]` is 1 exactly when every power bit of domain d is 0. Power bits outside all domain masks do not affect it.
- R10: A write with `wr_sel` 3 loads the settle delay (low 8 bits), which then sets the gaps of later sequences.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Domain change request, held until acknowledged |
| req_dom | input | 2 | Index of the requested domain |
| req_on | input | 1 | 1 = power up, 0 = power down |
| req_ack | output | 1 | One-cycle completion pulse |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 2 | Write target: 0 power, 1 isolation, 2 reset, 3 settle |
| wr_data | input | 32 | Write data |
| wr_stall | output | 1 | Writes are refused this cycle |
| rd_sel | input | 2 | Read target, same encoding as wr_sel |
| rd_data | output | 32 | Selected register value |
| pwr_off_o | output | 32 | Power word, 1 = domain switched off |
| iso_n_o | output | 32 | Isolation word, 0 = isolated |
| rst_n_o | output | 32 | Software reset word, 0 = held in reset |
| dom_on_o | output | 3 | Per-domain powered-up status |

## Verification
The ordering assertions assume that, during a sequence, only the sequencer alters the words. They also assume a requester keeps `req_valid`, `req_dom` and `req_on` steady until `req_ack` and drops `req_valid` before the next idle cycle. The bench drives writes only when the stall is low, except for one deliberate write during a sequence. It releases each request in the cycle after the acknowledge. The ordering checks also assume that a domain being powered up is still isolated and held in reset from its earlier power-down. The bench only powers up domains that it powered down itself.

// File: rtl/pwrdom_pkg.sv
package pwrdom_pkg;

    typedef enum logic [3:0] {
        S_IDLE,
        S_ISO_EN,
        S_RST_ASSERT,
        S_PWR_DOWN,
        S_PWR_UP,
        S_RST_RELEASE,
        S_ISO_DIS,
        S_SETTLE,
        S_ACK
    } seq_state_e;

    typedef enum logic [2:0] {
        OP_NONE,
        OP_ISO_EN,
        OP_RST_ASSERT,
        OP_PWR_DOWN,
        OP_PWR_UP,
        OP_RST_RELEASE,
        OP_ISO_DIS
    } seq_op_e;

    localparam logic [1:0] SEL_PWR    = 2'd0;
    localparam logic [1:0] SEL_ISO    = 2'd1;
    localparam logic [1:0] SEL_RST    = 2'd2;
    localparam logic [1:0] SEL_SETTLE = 2'd3;

endpackage

// File: rtl/pwrdom_mask_rom.sv
module pwrdom_mask_rom #(
    parameter int NUM_DOM = 3,
    parameter int REG_W   = 32,
    parameter int DOM_W   = 2,
    parameter logic [NUM_DOM*REG_W-1:0] PWR_MASKS = '0,
    parameter logic [NUM_DOM*REG_W-1:0] ISO_MASKS = '0,
    parameter logic [NUM_DOM*REG_W-1:0] RST_MASKS = '0
) (
    input  logic [DOM_W-1:0] idx,
    output logic [REG_W-1:0] pwr_m,
    output logic [REG_W-1:0] iso_m,
    output logic [REG_W-1:0] rst_m
);

    logic [REG_W-1:0] pwr_tab [NUM_DOM];
    logic [REG_W-1:0] iso_tab [NUM_DOM];
    logic [REG_W-1:0] rst_tab [NUM_DOM];

    for (genvar g = 0; g < NUM_DOM; g++) begin : g_tab
        assign pwr_tab[g] = PWR_MASKS[g*REG_W +: REG_W];
        assign iso_tab[g] = ISO_MASKS[g*REG_W +: REG_W];
        assign rst_tab[g] = RST_MASKS[g*REG_W +: REG_W];
    end

    // Out-of-range index yields empty masks: request is treated as already done.
    always_comb begin
        pwr_m = '0;
        iso_m = '0;
        rst_m = '0;
        for (int i = 0; i < NUM_DOM; i++) begin
            if (idx == DOM_W'(i)) begin
                pwr_m = pwr_tab[i];
                iso_m = iso_tab[i];
                rst_m = rst_tab[i];
            end
        end
    end

endmodule

// File: rtl/pwrdom_regs.sv
module pwrdom_regs
    import pwrdom_pkg::*;
#(
    parameter int REG_W      = 32,
    parameter int SETTLE_W   = 8,
    parameter int SETTLE_DEF = 16
) (
    input  logic                clk,
    input  logic                rst_n,
    input  seq_op_e             op,
    input  logic [REG_W-1:0]    pwr_m,
    input  logic [REG_W-1:0]    iso_m,
    input  logic [REG_W-1:0]    rst_m,
    input  logic                wr_en,
    input  logic [1:0]          wr_sel,
    input  logic [REG_W-1:0]    wr_data,
    input  logic                stall,
    input  logic [1:0]          rd_sel,
    output logic [REG_W-1:0]    rd_data,
    output logic [REG_W-1:0]    pwr_q,
    output logic [REG_W-1:0]    iso_q,
    output logic [REG_W-1:0]    rst_q,
    output logic [SETTLE_W-1:0] settle_q
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pwr_q    <= '0;
            iso_q    <= '1;
            rst_q    <= '1;
            settle_q <= SETTLE_W'(SETTLE_DEF);
        end else begin
            case (op)
                OP_ISO_EN:      iso_q <= iso_q & ~iso_m;
                OP_ISO_DIS:     iso_q <= iso_q | iso_m;
                OP_RST_ASSERT:  rst_q <= rst_q & ~rst_m;
                OP_RST_RELEASE: rst_q <= rst_q | rst_m;
                OP_PWR_DOWN:    pwr_q <= pwr_q | pwr_m;
                OP_PWR_UP:      pwr_q <= pwr_q & ~pwr_m;
                default: begin
                    if (wr_en && !stall) begin
                        case (wr_sel)
                            SEL_PWR: pwr_q    <= wr_data;
                            SEL_ISO: iso_q    <= wr_data;
                            SEL_RST: rst_q    <= wr_data;
                            default: settle_q <= wr_data[SETTLE_W-1:0];
                        endcase
                    end
                end
            endcase
        end
    end

    always_comb begin
        case (rd_sel)
            SEL_PWR: rd_data = pwr_q;
            SEL_ISO: rd_data = iso_q;
            SEL_RST: rd_data = rst_q;
            default: rd_data = REG_W'(settle_q);
        endcase
    end

endmodule

// File: rtl/pwrdom_fsm.sv
module pwrdom_fsm
    import pwrdom_pkg::*;
#(
    parameter int REG_W    = 32,
    parameter int SETTLE_W = 8,
    parameter int DOM_W    = 2
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                req_valid,
    input  logic [DOM_W-1:0]    req_dom,
    input  logic                req_on,
    input  logic [REG_W-1:0]    pwr_word,
    input  logic [REG_W-1:0]    pwr_m,
    input  logic [REG_W-1:0]    iso_m,
    input  logic [REG_W-1:0]    rst_m,
    input  logic [SETTLE_W-1:0] settle,
    output logic [DOM_W-1:0]    sel_dom,
    output seq_op_e             op,
    output logic                busy,
    output logic                ack
);

    seq_state_e          state_q, state_d, after_q, after_d, succ;
    logic [DOM_W-1:0]    dom_q, dom_d;
    logic [SETTLE_W-1:0] cnt_q, cnt_d;
    logic [REG_W-1:0]    step_m;
    logic                already;

    assign sel_dom = (state_q == S_IDLE) ? req_dom : dom_q;
    assign already = req_on ? ((pwr_word & pwr_m) == '0)
                            : ((pwr_word & pwr_m) == pwr_m);

    // Mask and successor of each step state.
    always_comb begin
        step_m = '0;
        succ   = S_ACK;
        case (state_q)
            S_ISO_EN:      begin step_m = iso_m; succ = S_RST_ASSERT;  end
            S_RST_ASSERT:  begin step_m = rst_m; succ = S_PWR_DOWN;    end
            S_PWR_DOWN:    begin step_m = pwr_m; succ = S_ACK;         end
            S_PWR_UP:      begin step_m = pwr_m; succ = S_RST_RELEASE; end
            S_RST_RELEASE: begin step_m = rst_m; succ = S_ISO_DIS;     end
            S_ISO_DIS:     begin step_m = iso_m; succ = S_ACK;         end
            default:       ;
        endcase
    end

    // State register.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= S_IDLE;
            after_q <= S_IDLE;
            dom_q   <= '0;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            after_q <= after_d;
            dom_q   <= dom_d;
            cnt_q   <= cnt_d;
        end
    end

    // Transitions.
    always_comb begin
        state_d = state_q;
        after_d = after_q;
        dom_d   = dom_q;
        cnt_d   = cnt_q;
        unique case (state_q)
            S_IDLE: begin
                if (req_valid) begin
                    dom_d   = req_dom;
                    state_d = already ? S_ACK : (req_on ? S_PWR_UP : S_ISO_EN);
                end
            end
            S_ISO_EN, S_RST_ASSERT, S_PWR_DOWN,
            S_PWR_UP, S_RST_RELEASE, S_ISO_DIS: begin
                if (step_m == '0 || settle == '0) begin
                    state_d = succ;
                end else begin
                    state_d = S_SETTLE;
                    after_d = succ;
                    cnt_d   = settle;
                end
            end
            S_SETTLE: begin
                if (cnt_q == SETTLE_W'(1)) state_d = after_q;
                else                       cnt_d   = cnt_q - SETTLE_W'(1);
            end
            S_ACK:   state_d = S_IDLE;
            default: state_d = S_IDLE;
        endcase
    end

    // Outputs.
    always_comb begin
        op   = OP_NONE;
        ack  = (state_q == S_ACK);
        busy = (state_q != S_IDLE) || req_valid;
        if (step_m != '0) begin
            case (state_q)
                S_ISO_EN:      op = OP_ISO_EN;
                S_RST_ASSERT:  op = OP_RST_ASSERT;
                S_PWR_DOWN:    op = OP_PWR_DOWN;
                S_PWR_UP:      op = OP_PWR_UP;
                S_RST_RELEASE: op = OP_RST_RELEASE;
                S_ISO_DIS:     op = OP_ISO_DIS;
                default:       op = OP_NONE;
            endcase
        end
    end

endmodule

// File: rtl/pwrdom_seq.sv
module pwrdom_seq
    import pwrdom_pkg::*;
#(
    parameter int NUM_DOM    = 3,
    parameter int REG_W      = 32,
    parameter int SETTLE_W   = 8,
    parameter int SETTLE_DEF = 16,
    parameter int DOM_W      = (NUM_DOM > 1) ? $clog2(NUM_DOM) : 1,
    parameter logic [NUM_DOM*REG_W-1:0] PWR_MASKS = {32'h0000_0010, 32'h0000_0004, 32'h0000_0008},
    parameter logic [NUM_DOM*REG_W-1:0] ISO_MASKS = {32'h0000_0020, 32'h0000_0002, 32'h0000_0001},
    parameter logic [NUM_DOM*REG_W-1:0] RST_MASKS = {32'h0000_0000, 32'h0004_0000, 32'h0001_0000}
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               req_valid,
    input  logic [DOM_W-1:0]   req_dom,
    input  logic               req_on,
    output logic               req_ack,
    input  logic               wr_en,
    input  logic [1:0]         wr_sel,
    input  logic [REG_W-1:0]   wr_data,
    output logic               wr_stall,
    input  logic [1:0]         rd_sel,
    output logic [REG_W-1:0]   rd_data,
    output logic [REG_W-1:0]   pwr_off_o,
    output logic [REG_W-1:0]   iso_n_o,
    output logic [REG_W-1:0]   rst_n_o,
    output logic [NUM_DOM-1:0] dom_on_o
);

    logic [DOM_W-1:0]    sel_dom;
    logic [REG_W-1:0]    pwr_m, iso_m, rst_m;
    logic [SETTLE_W-1:0] settle_q;
    seq_op_e             op;

    pwrdom_mask_rom #(
        .NUM_DOM(NUM_DOM), .REG_W(REG_W), .DOM_W(DOM_W),
        .PWR_MASKS(PWR_MASKS), .ISO_MASKS(ISO_MASKS), .RST_MASKS(RST_MASKS)
    ) u_rom (
        .idx(sel_dom), .pwr_m(pwr_m), .iso_m(iso_m), .rst_m(rst_m)
    );

    pwrdom_fsm #(.REG_W(REG_W), .SETTLE_W(SETTLE_W), .DOM_W(DOM_W)) u_fsm (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_dom(req_dom), .req_on(req_on),
        .pwr_word(pwr_off_o), .pwr_m(pwr_m), .iso_m(iso_m), .rst_m(rst_m),
        .settle(settle_q), .sel_dom(sel_dom), .op(op),
        .busy(wr_stall), .ack(req_ack)
    );

    pwrdom_regs #(.REG_W(REG_W), .SETTLE_W(SETTLE_W), .SETTLE_DEF(SETTLE_DEF)) u_regs (
        .clk(clk), .rst_n(rst_n), .op(op),
        .pwr_m(pwr_m), .iso_m(iso_m), .rst_m(rst_m),
        .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data), .stall(wr_stall),
        .rd_sel(rd_sel), .rd_data(rd_data),
        .pwr_q(pwr_off_o), .iso_q(iso_n_o), .rst_q(rst_n_o), .settle_q(settle_q)
    );

    for (genvar g = 0; g < NUM_DOM; g++) begin : g_on
        assign dom_on_o[g] = ((pwr_off_o & PWR_MASKS[g*REG_W +: REG_W]) == '0);
    end

endmodule

// File: rtl/pwrdom_seq_chk.sv
module pwrdom_seq_chk #(
    parameter int NUM_DOM  = 3,
    parameter int REG_W    = 32,
    parameter int SETTLE_W = 8,
    parameter logic [NUM_DOM*REG_W-1:0] PWR_MASKS = '0,
    parameter logic [NUM_DOM*REG_W-1:0] ISO_MASKS = '0,
    parameter logic [NUM_DOM*REG_W-1:0] RST_MASKS = '0
) (
    input logic                clk,
    input logic                rst_n,
    input logic                req_ack,
    input logic                wr_stall,
    input logic [REG_W-1:0]    pwr_off_o,
    input logic [REG_W-1:0]    iso_n_o,
    input logic [REG_W-1:0]    rst_n_o,
    input logic [SETTLE_W-1:0] settle_q
);

    for (genvar g = 0; g < NUM_DOM; g++) begin : g_dom
        localparam logic [REG_W-1:0] PM = PWR_MASKS[g*REG_W +: REG_W];
        localparam logic [REG_W-1:0] IM = ISO_MASKS[g*REG_W +: REG_W];
        localparam logic [REG_W-1:0] RM = RST_MASKS[g*REG_W +: REG_W];
        logic any_off, iso_free;
        assign any_off  = |(pwr_off_o & PM);
        assign iso_free = ((iso_n_o & IM) == IM) && (IM != '0);

        // R2
        pwr_down_after_iso_rst_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (wr_stall && $rose(any_off)) |-> (((iso_n_o & IM) == '0) && ((rst_n_o & RM) == '0)));

        // R3
        iso_free_after_pwr_rst_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (wr_stall && $rose(iso_free)) |-> (((pwr_off_o & PM) == '0) && ((rst_n_o & RM) == RM)));
    end

    // R5
    ack_single_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_ack |=> !req_ack);

    // R6
    stalled_write_dropped_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_stall |=> $stable(settle_q));

endmodule

bind pwrdom_seq pwrdom_seq_chk #(
    .NUM_DOM(NUM_DOM), .REG_W(REG_W), .SETTLE_W(SETTLE_W),
    .PWR_MASKS(PWR_MASKS), .ISO_MASKS(ISO_MASKS), .RST_MASKS(RST_MASKS)
) u_chk (
    .clk(clk), .rst_n(rst_n), .req_ack(req_ack), .wr_stall(wr_stall),
    .pwr_off_o(pwr_off_o), .iso_n_o(iso_n_o), .rst_n_o(rst_n_o),
    .settle_q(settle_q)
);

// File: tb/tb_pwrdom_seq.sv
module tb_pwrdom_seq;

    typedef struct {
        int          word;
        logic [31:0] val;
        int          gap;
        string       tag;
    } exp_t;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic [1:0]  req_dom = '0;
    logic        req_on = 1'b0;
    logic        req_ack;
    logic        wr_en = 1'b0;
    logic [1:0]  wr_sel = '0;
    logic [31:0] wr_data = '0;
    logic        wr_stall;
    logic [1:0]  rd_sel = '0;
    logic [31:0] rd_data;
    logic [31:0] pwr_off_o, iso_n_o, rst_n_o;
    logic [2:0]  dom_on_o;

    int nchk = 0;
    int nerr = 0;
    int cyc = 0;
    int last_chg = 0;
    logic [31:0] prev_pwr, prev_iso, prev_rst;
    exp_t exp_q[$];

    pwrdom_seq dut (.*);

    always #4 clk = ~clk;

    always @(posedge clk) cyc <= cyc + 1;

    always @(posedge clk) begin
        if (cyc > 20000) begin
            nerr++;
            $display("FAIL watchdog: run did not finish (act cyc=%0d exp <=20000)", cyc);
            $display("Result: errors=%0d of %0d checks", nerr, nchk);
            $finish;
        end
    end

    task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
        nchk++;
        if (act !== exp) begin
            nerr++;
            $display("FAIL %s: act=0x%08h exp=0x%08h", tag, act, exp);
        end
    endtask

    task automatic expect_chg(int w, logic [31:0] v, int g, string tag);
        exp_t e;
        e.word = w; e.val = v; e.gap = g; e.tag = tag;
        exp_q.push_back(e);
    endtask

    task automatic note_change(int w, logic [31:0] v);
        exp_t e;
        if (exp_q.size() == 0) begin
            nchk++; nerr++;
            $display("FAIL unexpected change of word %0d: act=0x%08h exp=no change", w, v);
        end else begin
            e = exp_q.pop_front();
            check({e.tag, " word"}, 32'(w), 32'(e.word));
            check({e.tag, " value"}, v, e.val);
            if (e.gap >= 0) check({e.tag, " gap"}, 32'(cyc - last_chg), 32'(e.gap));
        end
        last_chg = cyc;
    endtask

    // Monitor: pops the scoreboard on each observed word change.
    always @(negedge clk) begin
        if (rst_n) begin
            if (pwr_off_o !== prev_pwr) note_change(0, pwr_off_o);
            if (iso_n_o   !== prev_iso) note_change(1, iso_n_o);
            if (rst_n_o   !== prev_rst) note_change(2, rst_n_o);
        end
        prev_pwr = pwr_off_o;
        prev_iso = iso_n_o;
        prev_rst = rst_n_o;
    end

    task automatic bus_write(logic [1:0] sel, logic [31:0] data, string tag);
        if (sel != 2'd3) expect_chg(int'(sel), data, -1, tag);
        @(posedge clk); #1;
        wr_en = 1'b1; wr_sel = sel; wr_data = data;
        @(posedge clk); #1;
        wr_en = 1'b0;
    endtask

    task automatic read_chk(logic [1:0] sel, logic [31:0] exp, string tag);
        rd_sel = sel;
        #1;
        check(tag, rd_data, exp);
    endtask

    task automatic run_req(int dom, bit on, bit redundant, int settle, bit stall_try, string tag);
        int start;
        int n = 0;
        int ackc;
        bit got = 0;
        @(posedge clk); #1;
        req_dom = 2'(dom); req_on = on; req_valid = 1'b1;
        start = cyc;
        while (!got && n < 2000) begin
            @(negedge clk);
            if (req_ack) got = 1;
            else begin
                n++;
                if (stall_try && n == 3) begin
                    check("R6 stall high in sequence", 32'(wr_stall), 32'd1);
                    @(posedge clk); #1;
                    wr_en = 1'b1; wr_sel = 2'd3; wr_data = 32'd5;
                    @(posedge clk); #1;
                    wr_en = 1'b0;
                end
            end
        end
        ackc = cyc;
        @(posedge clk); #1;
        req_valid = 1'b0;
        check({tag, " ack seen"}, 32'(got), 32'd1);
        if (redundant) check({tag, " R7 ack latency"}, 32'(ackc - start), 32'd1);
        else           check({tag, " R5 ack after last change"}, 32'(ackc - last_chg), 32'(settle));
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check("R1 pwr", pwr_off_o, 32'h0);
        check("R1 iso", iso_n_o, 32'hFFFF_FFFF);
        check("R1 rst", rst_n_o, 32'hFFFF_FFFF);
        check("R1 dom_on", 32'(dom_on_o), 32'h7);
        check("R1 ack", 32'(req_ack), 32'h0);
        check("R1 stall", 32'(wr_stall), 32'h0);
        read_chk(2'd3, 32'd16, "R1 settle");

        // R2 power-down of domain 0
        expect_chg(1, 32'hFFFF_FFFE, -1, "R2 iso");
        expect_chg(2, 32'hFFFE_FFFF, 17, "R2 rst");
        expect_chg(0, 32'h0000_0008, 17, "R2 pwr");
        run_req(0, 0, 0, 16, 0, "R2 dom0 off");
        check("R9 dom_on after dom0 off", 32'(dom_on_o), 32'h6);

        // R6 power-down of domain 1 with a stalled write
        expect_chg(1, 32'hFFFF_FFFC, -1, "R6 iso");
        expect_chg(2, 32'hFFFA_FFFF, 17, "R6 rst");
        expect_chg(0, 32'h0000_000C, 17, "R6 pwr");
        run_req(1, 0, 0, 16, 1, "R6 dom1 off");
        read_chk(2'd3, 32'd16, "R6 stalled settle write dropped");
        check("R9 dom_on after dom1 off", 32'(dom_on_o), 32'h4);

        // R7 redundant power-down
        run_req(0, 0, 1, 16, 0, "R7 dom0 off again");
        check("R7 pwr unchanged", pwr_off_o, 32'h0000_000C);

        // R3 power-up of domain 0
        expect_chg(0, 32'h0000_0004, -1, "R3 pwr");
        expect_chg(2, 32'hFFFB_FFFF, 17, "R3 rst");
        expect_chg(1, 32'hFFFF_FFFD, 17, "R3 iso");
        run_req(0, 1, 0, 16, 0, "R3 dom0 on");

        // R4 domain 2 has no reset bits
        expect_chg(1, 32'hFFFF_FFDD, -1, "R4 iso");
        expect_chg(0, 32'h0000_0014, 18, "R4 pwr skip rst");
        run_req(2, 0, 0, 16, 0, "R4 dom2 off");
        expect_chg(0, 32'h0000_0004, -1, "R4 pwr up");
        expect_chg(1, 32'hFFFF_FFFD, 18, "R4 iso skip rst");
        run_req(2, 1, 0, 16, 0, "R4 dom2 on");

        // R10 shorter settle, then power-up of domain 1
        bus_write(2'd3, 32'd3, "R10 settle");
        read_chk(2'd3, 32'd3, "R10 settle readback");
        expect_chg(0, 32'h0000_0000, -1, "R10 pwr");
        expect_chg(2, 32'hFFFF_FFFF, 4, "R10 rst");
        expect_chg(1, 32'hFFFF_FFFF, 4, "R10 iso");
        run_req(1, 1, 0, 3, 0, "R10 dom1 on");
        check("R9 dom_on all on", 32'(dom_on_o), 32'h7);
        run_req(1, 1, 1, 3, 0, "R7 dom1 on again");

        // R8 reset pulse via two writes
        bus_write(2'd2, 32'hFFFF_FF7F, "R8 pulse low");
        read_chk(2'd2, 32'hFFFF_FF7F, "R8 rst held");
        bus_write(2'd2, 32'hFFFF_FFFF, "R8 pulse high");
        read_chk(2'd2, 32'hFFFF_FFFF, "R8 rst released");
        bus_write(2'd1, 32'hFFFF_0FFF, "R8 iso write");
        read_chk(2'd1, 32'hFFFF_0FFF, "R8 iso readback");
        bus_write(2'd1, 32'hFFFF_FFFF, "R8 iso restore");

        // R9 power bits by software
        bus_write(2'd0, 32'h0000_0001, "R9 unmapped pwr bit");
        @(negedge clk);
        check("R9 dom_on ignores unmapped bit", 32'(dom_on_o), 32'h7);
        bus_write(2'd0, 32'h0000_0008, "R9 dom0 bit");
        @(negedge clk);
        check("R9 dom_on dom0 off", 32'(dom_on_o), 32'h6);
        read_chk(2'd0, 32'h0000_0008, "R8 pwr readback");
        bus_write(2'd0, 32'h0000_0000, "R9 restore");

        repeat (4) @(negedge clk);
        check("scoreboard drained", 32'(exp_q.size()), 32'd0);
        $display("Result: errors=%0d of %0d checks", nerr, nchk);
        $finish;
    end

endmodule